// File: doc/BRIEF.md
# Burst SPI Master

This block is an SPI master that runs one burst of a programmable number of bits, from 1 up to 2^12. Software reaches it through a small word-wide register port. It loads 32-bit words into a transmit FIFO, picks one of four chip-select channels, and then sets an exchange bit to start the burst. The engine moves bits out of the transmit FIFO most-significant bit first. It collects the incoming bits into 32-bit words and pushes them into a receive FIFO. When a burst's bit count is not a multiple of 32, the first word holds the odd bits, right-aligned. Every later word is full.

The configuration register gives each channel its own settings: chip-select polarity, clock polarity, resting clock level and clock phase. The serial clock comes from a linear pre-divider followed by a power-of-two post-divider. Two sticky status flags record a finished burst and a receive word lost to a full FIFO. Software clears them by writing ones.

The engine is a five-state machine:
- ST_IDLE: chip selects inactive, clock at rest. A pending exchange moves it to ST_FETCH.
- ST_FETCH: takes one word from the transmit FIFO. It then always moves to ST_FIRST_HALF.
- ST_FIRST_HALF: clock at its polarity level. A divider tick moves it to ST_SECOND_HALF.
- ST_SECOND_HALF: clock at the opposite level. On a divider tick it goes to one of three states:
  - ST_FIRST_HALF if the word has bits left;
  - ST_FETCH if the word is done and the burst is not;
  - ST_TRAIL after the last bit.
- ST_TRAIL: holds the chip select for one more half period. A tick then returns it to ST_IDLE and signals completion.

Top module: `spi_burst_master`

## Requirements
- R1: After reset:
  - every register reads zero;
  - sclk is 0;
  - all four cs_o lines are high (inactive for the reset polarity 0).
- R2: A burst of length L (control bits [23:12] = L-1) produces exactly L leading clock edges. Completion then sets the done flag, status bit 0.
- R3: Bits leave on mosi in this order:
  - first the low L mod 32 bits of the first transmit word, from its highest bit down (when L mod 32 is not 0);
  - then each following word from bit 31 down to bit 0.
- R4: Received bits fill receive words in the same layout as the transmit words. Reading address 0 returns the oldest receive word, or 0 when the receive FIFO is empty. With mosi looped to miso, each receive word equals its transmit word masked to the bits that were sent.
- R5: A write to the control register (address 1) sets bit 1, the exchange bit, only if bit 0, the enable bit, is also set. A burst starts only then. The exchange bit reads back 1 while the burst runs and clears itself at completion. Control writes during a burst are ignored.
- R6: Writing status (address 3) with bit 0 or bit 1 set clears the done flag or the overflow flag respectively.
- R7: Control bits [3:2] select the channel.
  - Only that channel's cs_o goes active for the whole burst. Its active level is configuration bit [ch]: 1 means active high.
  - The line goes inactive one half period after the last trailing edge.
- R8: The clock polarity is configuration bit [4+ch]. During a burst the clock rests at that level between bits, and the leading edge leaves it.
  - When configuration bit [12+ch], the phase bit, is 0, data is valid on the leading edge.
  - When the phase bit is 1, data changes on the leading edge and is valid on the trailing edge.
- R9: Between bursts, sclk rests at configuration bit [8+ch] of the selected channel.
- R10: Each clock half period lasts (pre+1)·2^post cycles of clk. pre is control bits [7:4] and post is control bits [11:8].
- R11: A write to address 0 when the transmit FIFO (64 words) is full is dropped. When the transmit FIFO is empty, a word slot shifts out zeros.
- R12: A receive word that arrives while the receive FIFO is full is discarded and sets the overflow flag, status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 0) |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 configuration, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip selects, one per channel |

## Verification
The assertions assume three things:
- Software does not rewrite the configuration register while a burst runs. The chip-select release check compares against the live polarity bits.
- A status clear never lands on the same cycle as completion, so a write-one-to-clear always wins its cycle.
- Register strobes are single-cycle pulses.

The stimulus keeps within these limits. It writes the configuration only before starting a burst. It polls status for completion before clearing it. It drives every access as one-cycle strobes set up away from the clock edge.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    localparam int WORD_W = 32;
    localparam int NCS    = 4;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_CFG  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FIRST_HALF,
        ST_SECOND_HALF,
        ST_TRAIL
    } state_t;
endpackage

// File: rtl/sbm_fifo.sv
module sbm_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [LW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/sbm_clkdiv.sv
module sbm_clkdiv #(
    parameter int PRE_W  = 4,
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRE_W-1:0]  pre,
    input  logic [POST_W-1:0] post,
    output logic              tick
);
    localparam int CNT_W = PRE_W + (1 << POST_W);

    logic [CNT_W-1:0] cnt, lim;

    assign lim  = (CNT_W'(pre) + 1'b1) << post;
    assign tick = run && (cnt == lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sbm_engine.sv
module sbm_engine
    import sbm_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              idle_lvl,
    input  logic              tick,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              miso,
    output logic              busy,
    output logic              run,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              done,
    output logic              sclk,
    output logic              mosi
);
    localparam int CNT_W = LEN_W + 1;
    localparam int WB_W  = $clog2(WORD_W) + 1;

    state_t            state, nxt;
    logic [CNT_W-1:0]  left;
    logic [WB_W-1:0]   wbits, k, sa;
    logic [WB_W-2:0]   rem;
    logic [WORD_W-1:0] sh, rxs, samp;
    logic              prev;

    assign rem  = left[WB_W-2:0];
    assign k    = (rem == '0) ? WB_W'(WORD_W) : {1'b0, rem};
    assign sa   = WB_W'(WORD_W) - k;
    assign samp = {rxs[WORD_W-2:0], miso};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:        if (start) nxt = ST_FETCH;
            ST_FETCH:       nxt = ST_FIRST_HALF;
            ST_FIRST_HALF:  if (tick) nxt = ST_SECOND_HALF;
            ST_SECOND_HALF: if (tick) begin
                if (wbits != WB_W'(1))      nxt = ST_FIRST_HALF;
                else if (left != CNT_W'(1)) nxt = ST_FETCH;
                else                        nxt = ST_TRAIL;
            end
            ST_TRAIL:       if (tick) nxt = ST_IDLE;
            default:        nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left  <= '0;
            wbits <= '0;
            sh    <= '0;
            rxs   <= '0;
            prev  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    left <= {1'b0, len_m1} + 1'b1;
                    prev <= 1'b0;
                end
                ST_FETCH: begin
                    sh    <= tx_empty ? '0 : (tx_data << sa);
                    wbits <= k;
                    rxs   <= '0;
                end
                ST_FIRST_HALF: if (tick && !cpha) rxs <= samp;
                ST_SECOND_HALF: if (tick) begin
                    if (cpha) rxs <= samp;
                    sh    <= sh << 1;
                    prev  <= sh[WORD_W-1];
                    wbits <= wbits - 1'b1;
                    left  <= left - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy    = (state != ST_IDLE);
        run     = (state == ST_FIRST_HALF) || (state == ST_SECOND_HALF) || (state == ST_TRAIL);
        tx_pop  = (state == ST_FETCH) && !tx_empty;
        rx_push = (state == ST_SECOND_HALF) && tick && (wbits == WB_W'(1));
        rx_data = cpha ? samp : rxs;
        done    = (state == ST_TRAIL) && tick;
        unique case (state)
            ST_IDLE:        begin sclk = idle_lvl; mosi = 1'b0;           end
            ST_SECOND_HALF: begin sclk = ~cpol;    mosi = sh[WORD_W-1];  end
            default:        begin sclk = cpol;     mosi = cpha ? prev : sh[WORD_W-1]; end
        endcase
    end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import sbm_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int LEN_W      = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs_o
);
    localparam int LEN_LSB = 12;
    localparam int CFG_W   = 4 * NCS;

    logic             en_q, go_q, tc_q, ovf_q;
    logic [1:0]       chan_q;
    logic [3:0]       pre_q, post_q;
    logic [LEN_W-1:0] len_q;
    logic [CFG_W-1:0] cfg_q;
    logic [NCS-1:0]   g_pol, g_cpol, g_idle, g_cpha;

    logic              busy_w, run_w, tick_w, done_w;
    logic              tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              wr_ctrl, wr_stat;

    assign g_pol   = cfg_q[0*NCS +: NCS];
    assign g_cpol  = cfg_q[1*NCS +: NCS];
    assign g_idle  = cfg_q[2*NCS +: NCS];
    assign g_cpha  = cfg_q[3*NCS +: NCS];
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL) && !busy_w;
    assign wr_stat = reg_wr && (reg_addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; go_q <= 1'b0; chan_q <= '0; pre_q <= '0; post_q <= '0;
            len_q <= '0; cfg_q <= '0; tc_q <= 1'b0; ovf_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= reg_wdata[0];
                go_q   <= reg_wdata[0] & reg_wdata[1];
                chan_q <= reg_wdata[3:2];
                pre_q  <= reg_wdata[7:4];
                post_q <= reg_wdata[11:8];
                len_q  <= reg_wdata[LEN_LSB +: LEN_W];
            end else if (done_w) begin
                go_q <= 1'b0;
            end
            if (reg_wr && (reg_addr == A_CFG)) cfg_q <= reg_wdata[CFG_W-1:0];
            tc_q  <= done_w | (tc_q & ~(wr_stat & reg_wdata[0]));
            ovf_q <= (rx_push & rx_full) | (ovf_q & ~(wr_stat & reg_wdata[1]));
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_DATA:  reg_rdata = rx_empty ? '0 : rx_head;
            A_CTRL:  reg_rdata = 32'({len_q, post_q, pre_q, chan_q, go_q, en_q});
            A_CFG:   reg_rdata = 32'(cfg_q);
            default: reg_rdata = {30'b0, ovf_q, tc_q};
        endcase
    end

    generate
        for (genvar g = 0; g < NCS; g++) begin : g_cs
            assign cs_o[g] = (busy_w && (chan_q == 2'(g))) ? g_pol[g] : ~g_pol[g];
        end
    endgenerate

    sbm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(reg_wr && (reg_addr == A_DATA)), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    sbm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(reg_rd && (reg_addr == A_DATA)), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
    );

    sbm_clkdiv #(.PRE_W(4), .POST_W(4)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run_w), .pre(pre_q), .post(post_q), .tick(tick_w)
    );

    sbm_engine #(.LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(go_q), .len_m1(len_q),
        .cpol(g_cpol[chan_q]), .cpha(g_cpha[chan_q]), .idle_lvl(g_idle[chan_q]),
        .tick(tick_w), .tx_empty(tx_empty), .tx_data(tx_head), .miso(miso),
        .busy(busy_w), .run(run_w), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
        .done(done_w), .sclk(sclk), .mosi(mosi)
    );
endmodule

// File: rtl/sbm_chk.sv
module sbm_chk
    import sbm_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              busy,
    input logic              done,
    input logic              tc,
    input logic              ovf,
    input logic              tx_full,
    input logic              tx_pop,
    input logic [3:0]        cs_o,
    input logic [3:0]        cs_pol,
    input logic [LEN_W+10:0] ctrl_fields
);
    a_r2_done_sets_tc: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> tc);

    a_r6_tc_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata[0] && !done) |=> !tc);

    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(reg_wr && reg_addr == A_STAT && reg_wdata[1])) |=> ovf);

    a_r5_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == A_CTRL) |=> $stable(ctrl_fields));

    a_r7_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cs_o == ~cs_pol));

    a_r11_tx_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !tx_pop) |=> tx_full);
endmodule

bind spi_burst_master sbm_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy_w), .done(done_w), .tc(tc_q), .ovf(ovf_q), .tx_full(tx_full), .tx_pop(tx_pop),
    .cs_o(cs_o), .cs_pol(g_pol), .ctrl_fields({en_q, chan_q, pre_q, post_q, len_q})
);

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
    import sbm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_o;

    assign miso = mosi;
    always #(CLK_PERIOD/2) clk = ~clk;

    spi_burst_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o)
    );

    int checks = 0, fails = 0;
    logic [31:0] txw [0:127];
    bit   capb [0:4199];
    int   nlead, ncap, t1, t2, cyc;
    bit   armed, mon_on;
    logic prev_sclk = 1'b0;
    logic [3:0] cs_snap;
    int   cur_chan;
    bit   cur_cpol, cur_cpha, cur_csp;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (mon_on && rst_n && cs_o[cur_chan] == cur_csp && sclk !== prev_sclk) begin
            if (sclk != cur_cpol) begin
                nlead++;
                if (nlead == 1) begin t1 = cyc; cs_snap = cs_o; end
                if (nlead == 2) t2 = cyc;
                if (!cur_cpha) begin capb[ncap] = mosi; ncap++; end
                armed = 1;
            end else if (armed) begin
                if (cur_cpha) begin capb[ncap] = mosi; ncap++; end
                armed = 0;
            end
        end
        prev_sclk = sclk;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] ctrlw(int lm1, int post, int pre, int chan, int go, int en);
        return 32'((lm1 << 12) | (post << 8) | (pre << 4) | (chan << 2) | (go << 1) | en);
    endfunction

    function automatic logic [31:0] sent_word(int w);
        return (w < DEPTH) ? txw[w] : 32'h0;
    endfunction

    function automatic bit exp_bit(int j, int n);
        int fk = (n % 32 != 0) ? n % 32 : 32;
        logic [31:0] wv;
        if (j < fk) begin
            wv = sent_word(0);
            return wv[fk - 1 - j];
        end
        wv = sent_word(1 + (j - fk) / 32);
        return wv[31 - ((j - fk) % 32)];
    endfunction

    task automatic run_burst(input int chan, input bit cpol, input bit cpha, input bit idl,
                             input int pre, input int post, input int n, input bit poke);
        int nbw = (n + 31) / 32;
        int fk  = (n % 32 != 0) ? n % 32 : 32;
        int bad = 0;
        bit ok  = 0;
        logic [31:0] d, m;
        logic [15:0] cfgv;
        logic [3:0]  pol, exp_cs;
        cfgv = 16'($urandom);
        cfgv[4 + chan] = cpol; cfgv[8 + chan] = idl; cfgv[12 + chan] = cpha;
        pol = cfgv[3:0];
        cur_chan = chan; cur_cpol = cpol; cur_cpha = cpha; cur_csp = pol[chan];
        wr(A_CFG, {16'h0, cfgv});
        for (int i = 0; i < nbw; i++) begin
            txw[i] = $urandom;
            wr(A_DATA, txw[i]);
        end
        nlead = 0; ncap = 0; armed = 0; mon_on = 1; cs_snap = 'x;
        wr(A_CTRL, ctrlw(n - 1, post, pre, chan, 1, 1));
        if (poke) begin
            rd(A_CTRL, d);
            chk(d[1] == 1'b1, "R5 exchange bit while busy", 32'(d[1]), 1);
            wr(A_CTRL, ctrlw(5, 0, 0, 3, 1, 1));
        end
        for (int p = 0; p < 20000 && !ok; p++) begin
            rd(A_STAT, d);
            ok = d[0];
        end
        chk(ok, "R2 done flag", 32'(ok), 1);
        chk(nlead == n, "R2 leading edge count", nlead, n);
        chk(ncap == n, "R8 sampled bit count", ncap, n);
        for (int j = 0; j < n && j < ncap; j++) if (capb[j] != exp_bit(j, n)) bad++;
        chk(bad == 0, "R3 bit order mismatches", bad, 0);
        for (int g = 0; g < 4; g++) exp_cs[g] = (g == chan) ? pol[g] : ~pol[g];
        chk(cs_snap == exp_cs, "R7 chip select during burst", 32'(cs_snap), 32'(exp_cs));
        chk(cs_o == ~pol, "R7 chip select after burst", 32'(cs_o), 32'(~pol));
        chk(sclk == idl, "R9 resting clock level", 32'(sclk), 32'(idl));
        if (fk >= 2)
            chk(t2 - t1 == 2 * ((pre + 1) << post), "R10 clock period", t2 - t1, 2 * ((pre + 1) << post));
        rd(A_STAT, d);
        chk(d[1] == (nbw > DEPTH), "R12 overflow flag", 32'(d[1]), 32'(nbw > DEPTH));
        for (int i = 0; i < nbw && i < DEPTH; i++) begin
            m = (i == 0 && fk < 32) ? ((32'h1 << fk) - 1) : 32'hFFFF_FFFF;
            rd(A_DATA, d);
            chk(d == (sent_word(i) & m), "R4 receive word", d, sent_word(i) & m);
        end
        if (nbw > DEPTH) begin
            rd(A_DATA, d);
            chk(d == 0, "R12 overflowing word discarded", d, 0);
        end
        rd(A_CTRL, d);
        chk(d[1] == 0 && d[3:2] == 2'(chan) && d[23:12] == 12'(n - 1), "R5 exchange self-clear and locked fields",
            d, ctrlw(n - 1, post, pre, chan, 0, 1));
        wr(A_STAT, 32'h3);
        rd(A_STAT, d);
        chk(d[1:0] == 2'b00, "R6 status clear", d, 0);
        mon_on = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        cur_chan = 0; cur_cpol = 0; cur_cpha = 0; cur_csp = 0; mon_on = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(sclk == 1'b0, "R1 reset sclk", 32'(sclk), 0);
        chk(cs_o == 4'hF, "R1 reset chip selects", 32'(cs_o), 32'hF);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk(d == 0, "R1 reset register value", d, 0);
        end

        nlead = 0; mon_on = 1;
        wr(A_CTRL, ctrlw(7, 0, 0, 0, 1, 0));
        repeat (100) @(negedge clk);
        rd(A_STAT, d);
        chk(d[0] == 0, "R5 no burst without enable", d, 0);
        chk(nlead == 0, "R5 no clock without enable", nlead, 0);
        rd(A_CTRL, d);
        chk(d[1] == 0, "R5 exchange bit refused", 32'(d[1]), 0);
        mon_on = 0;

        run_burst(0, 0, 0, 0, 0, 0, 1,  0);
        run_burst(1, 1, 0, 1, 1, 0, 32, 0);
        run_burst(2, 0, 1, 1, 0, 1, 33, 0);
        run_burst(3, 1, 1, 0, 2, 0, 31, 0);
        run_burst(0, 0, 1, 0, 0, 0, 64, 0);
        run_burst(1, 0, 0, 0, 2, 1, 100, 1);
        run_burst(2, 0, 0, 1, 0, 0, DEPTH * 32 + 32, 0);
        for (int r = 0; r < 10; r++)
            run_burst(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                      int'($urandom % 3), int'($urandom % 2), 1 + int'($urandom % 200), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule